// File: doc/BRIEF.md
# Dual-Channel Three-Tap FIR Filter Bank

The block filters two independent streams of signed 16-bit samples. Each stream has its own valid flag and its own fixed three-tap integer kernel. Channel 0 smooths its input with the kernel 1, 2, 1. Channel 1 picks out rapid changes with the kernel 1, -2, 1. Both channels are built from the same two-stage pipelined multiply-accumulate unit. They differ only in the coefficient values that the unit is given.

A small sequencer runs the bank through five phases: idle, coefficient loading, running, draining and done. A start pulse leaves idle. Loading then writes one tap's coefficient per cycle into each channel's coefficient registers. Samples are taken only while running. An input-done pulse moves the bank into draining, which pushes zeros through the delay lines so that the tail of every response comes out. The bank then waits in done until the next reset.

Top module: `dual_fir_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the bank goes to idle (`state_o` = 0), clears both output valids, the delay lines and the pipeline. After a restart, no sample from before the reset contributes to any result.
- R2: In idle, `start_i` high at a clock edge moves `state_o` to loading (code 1) at that edge. Otherwise the bank stays in idle. `start_i` has no effect in any other phase.
- R3: Loading (code 1) lasts exactly 3 cycles, one per tap. Running (code 2) follows. Running holds until `in_done_i` is seen.
- R4: While running, a sample with its valid bit high is captured at a clock edge. The result and its valid flag appear at the second edge after the capture edge. The valid flag is high for exactly one cycle per captured sample.
- R5: The result of channel c is the sum over k = 0..2 of coef_c[k] times x[n-k], where x[n] is the newest captured sample. Channel 0 uses coefficients {1, 2, 1} and channel 1 uses {1, -2, 1}. An isolated 1 followed by zeros therefore yields the coefficients in order.
- R6: Samples presented in idle, loading or done, and samples with the valid bit low while running, are not captured. They produce no output valid and do not enter the delay line.
- R7: `in_done_i` high at an edge while running moves the bank to draining (code 3). A sample valid in that same cycle is still captured. Draining lasts exactly 5 cycles (taps plus the two MAC stages). Each draining cycle captures a zero and produces a valid result.
- R8: After draining, the bank enters done (code 4) and stays there, ignoring `start_i`, until reset.
- R9: Results are 22-bit two's complement numbers (16 data bits + 4 coefficient bits + 2 guard bits). Full-scale inputs of -32768 and 32767 never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, acted on in idle only |
| in_done_i | input | 1 | End-of-input pulse, acted on while running |
| ch0_data_i | input | 16 | Channel 0 signed sample |
| ch0_valid_i | input | 1 | Channel 0 sample valid |
| ch1_data_i | input | 16 | Channel 1 signed sample |
| ch1_valid_i | input | 1 | Channel 1 sample valid |
| ch0_res_o | output | 22 | Channel 0 filtered result, signed |
| ch0_res_vld_o | output | 1 | Channel 0 result valid |
| ch1_res_o | output | 22 | Channel 1 filtered result, signed |
| ch1_res_vld_o | output | 1 | Channel 1 result valid |
| state_o | output | 3 | Sequencer phase: 0 idle, 1 loading, 2 running, 3 draining, 4 done |

## Verification
A wrong coefficient register or a stale delay-line entry appears at the result port within two cycles of the next captured sample. It persists for up to three consecutive results, so a single impulse per channel exposes it. A sequencer that miscounts shows on `state_o` in the very cycle the phase should change. The effect also reaches the outputs: a short drain loses the last valid results, and a long load drops the first running sample. A broken valid pipeline shows as a result flag one cycle early or late against a bench model that tracks every capture edge. Full-scale alternating inputs expose any accumulator that is too narrow as a sign flip in the output.

// File: rtl/dual_fir_pkg.sv
// Shared definitions for the dual-channel filter bank.
// Assumes: the multiply-accumulate unit has a fixed two-register latency.
package dual_fir_pkg;

    // Register stages inside the multiply-accumulate unit.
    localparam int MAC_LAT = 2;

    // Sequencer phases; the codes are visible on the top-level state port.
    typedef enum logic [2:0] {
        FB_IDLE  = 3'd0,
        FB_LOAD  = 3'd1,
        FB_RUN   = 3'd2,
        FB_DRAIN = 3'd3,
        FB_DONE  = 3'd4
    } fb_state_e;

endpackage

// File: rtl/fir_seq_ctrl.sv
// Phase sequencer for the filter bank.
// Walks idle -> load (TAPS cycles) -> run -> drain (TAPS + MAC_LAT cycles) -> done.
// Assumes: start and input-done are single-cycle pulses; done is left only by reset.
module fir_seq_ctrl
    import dual_fir_pkg::*;
#(
    parameter int TAPS = 3,
    parameter int CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            in_done_i,
    output fb_state_e       state_o,
    output logic [CW-1:0]   step_o
);

    localparam int DRAIN_LEN = TAPS + MAC_LAT;

    fb_state_e       st_q;
    logic [CW-1:0]   cnt_q;

    // Advance the phase and the per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FB_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                FB_IDLE: begin
                    if (start_i) begin
                        st_q  <= FB_LOAD;
                        cnt_q <= '0;
                    end
                end
                FB_LOAD: begin
                    if (cnt_q == CW'(TAPS - 1)) begin
                        st_q  <= FB_RUN;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                FB_RUN: begin
                    if (in_done_i) begin
                        st_q  <= FB_DRAIN;
                        cnt_q <= '0;
                    end
                end
                FB_DRAIN: begin
                    if (cnt_q == CW'(DRAIN_LEN - 1)) begin
                        st_q  <= FB_DONE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                FB_DONE: begin
                    st_q <= FB_DONE;
                end
                default: begin
                    st_q  <= FB_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign state_o = st_q;
    assign step_o  = cnt_q;

endmodule

// File: rtl/fir_mac.sv
// Two-stage pipelined multiply-accumulate over a full tap window.
// Stage 1 registers one product per tap; stage 2 registers their sum.
// Assumes: ACC_W > DATA_W + COEF_W, so the sum is sign-extended without loss.
module fir_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 4,
    parameter int TAPS   = 3,
    parameter int ACC_W  = 22
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid_i,
    input  logic [TAPS*DATA_W-1:0]    taps_i,
    input  logic [TAPS*COEF_W-1:0]    coefs_i,
    output logic signed [ACC_W-1:0]   res_o,
    output logic                      res_valid_o
);

    localparam int PW = DATA_W + COEF_W;

    logic signed [PW-1:0]    tap_x  [TAPS];
    logic signed [PW-1:0]    coef_x [TAPS];
    logic signed [PW-1:0]    prod_q [TAPS];
    logic                    v1_q;
    logic signed [ACC_W-1:0] sum_d;
    logic signed [ACC_W-1:0] res_q;
    logic                    v2_q;

    // Sign-extend every tap and coefficient to the product width.
    always_comb begin
        for (int k = 0; k < TAPS; k++) begin
            tap_x[k]  = $signed({{COEF_W{taps_i[k*DATA_W + DATA_W - 1]}},
                                 taps_i[k*DATA_W +: DATA_W]});
            coef_x[k] = $signed({{DATA_W{coefs_i[k*COEF_W + COEF_W - 1]}},
                                 coefs_i[k*COEF_W +: COEF_W]});
        end
    end

    // Stage 1: register one product per tap and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) prod_q[k] <= '0;
            v1_q <= 1'b0;
        end else begin
            for (int k = 0; k < TAPS; k++) prod_q[k] <= tap_x[k] * coef_x[k];
            v1_q <= in_valid_i;
        end
    end

    // Add the sign-extended products together.
    always_comb begin
        sum_d = '0;
        for (int k = 0; k < TAPS; k++) begin
            sum_d = sum_d + $signed({{(ACC_W-PW){prod_q[k][PW-1]}}, prod_q[k]});
        end
    end

    // Stage 2: register the sum and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            v2_q  <= 1'b0;
        end else begin
            res_q <= sum_d;
            v2_q  <= v1_q;
        end
    end

    assign res_o       = res_q;
    assign res_valid_o = v2_q;

endmodule

// File: rtl/fir_chan.sv
// One filter channel: the sample delay line, the coefficient registers
// loaded by the sequencer, and one pipelined multiply-accumulate unit.
// Assumes: load_idx_i counts 0..TAPS-1 while load_we_i is high;
// flush_i and feed_i are never high together.
module fir_chan #(
    parameter int                      DATA_W = 16,
    parameter int                      COEF_W = 4,
    parameter int                      TAPS   = 3,
    parameter int                      ACC_W  = 22,
    parameter int                      CW     = 3,
    parameter logic [TAPS*COEF_W-1:0]  COEFS  = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      feed_i,
    input  logic                      flush_i,
    input  logic                      load_we_i,
    input  logic [CW-1:0]             load_idx_i,
    input  logic [DATA_W-1:0]         data_i,
    input  logic                      valid_i,
    output logic signed [ACC_W-1:0]   res_o,
    output logic                      res_valid_o
);

    logic [DATA_W-1:0]        dl_q   [TAPS];
    logic [COEF_W-1:0]        coef_q [TAPS];
    logic                     v0_q;
    logic                     accept;
    logic [DATA_W-1:0]        shift_in;
    logic [TAPS*DATA_W-1:0]   taps_pk;
    logic [TAPS*COEF_W-1:0]   coef_pk;

    assign accept   = (feed_i & valid_i) | flush_i;
    assign shift_in = flush_i ? '0 : data_i;

    // Shift a captured sample (or a flush zero) into the delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) dl_q[k] <= '0;
            v0_q <= 1'b0;
        end else begin
            if (accept) begin
                dl_q[0] <= shift_in;
                for (int k = 1; k < TAPS; k++) dl_q[k] <= dl_q[k-1];
            end
            v0_q <= accept;
        end
    end

    // Write one coefficient per loading cycle from the channel's fixed kernel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) coef_q[k] <= '0;
        end else if (load_we_i) begin
            for (int k = 0; k < TAPS; k++) begin
                if (load_idx_i == CW'(k)) coef_q[k] <= COEFS[k*COEF_W +: COEF_W];
            end
        end
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_pack
        assign taps_pk[g*DATA_W +: DATA_W] = dl_q[g];
        assign coef_pk[g*COEF_W +: COEF_W] = coef_q[g];
    end

    fir_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .TAPS   (TAPS),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (v0_q),
        .taps_i      (taps_pk),
        .coefs_i     (coef_pk),
        .res_o       (res_o),
        .res_valid_o (res_valid_o)
    );

endmodule

// File: rtl/dual_fir_bank.sv
// Top level: two filter channels with distinct fixed kernels, run by one sequencer.
// Assumes: coefficient vectors hold tap 0 (applied to the newest sample)
// in the least significant field.
module dual_fir_bank
    import dual_fir_pkg::*;
#(
    parameter int                      DATA_W    = 16,
    parameter int                      COEF_W    = 4,
    parameter int                      TAPS      = 3,
    parameter logic [TAPS*COEF_W-1:0]  CH0_COEFS = {4'd1, 4'd2, 4'd1},
    parameter logic [TAPS*COEF_W-1:0]  CH1_COEFS = {4'd1, 4'hE, 4'd1}
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_i,
    input  logic                             in_done_i,
    input  logic [DATA_W-1:0]                ch0_data_i,
    input  logic                             ch0_valid_i,
    input  logic [DATA_W-1:0]                ch1_data_i,
    input  logic                             ch1_valid_i,
    output logic signed [DATA_W+COEF_W+1:0]  ch0_res_o,
    output logic                             ch0_res_vld_o,
    output logic signed [DATA_W+COEF_W+1:0]  ch1_res_o,
    output logic                             ch1_res_vld_o,
    output logic [2:0]                       state_o
);

    localparam int ACC_W = DATA_W + COEF_W + 2;
    localparam int NCH   = 2;
    localparam int CW    = $clog2(TAPS + MAC_LAT + 1);

    fb_state_e               st;
    logic [CW-1:0]           step;
    logic [DATA_W-1:0]       din   [NCH];
    logic                    dvld  [NCH];
    logic signed [ACC_W-1:0] res   [NCH];
    logic                    rvld  [NCH];

    assign din[0]  = ch0_data_i;
    assign din[1]  = ch1_data_i;
    assign dvld[0] = ch0_valid_i;
    assign dvld[1] = ch1_valid_i;

    fir_seq_ctrl #(
        .TAPS (TAPS),
        .CW   (CW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .in_done_i (in_done_i),
        .state_o   (st),
        .step_o    (step)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [TAPS*COEF_W-1:0] KERN = (g == 0) ? CH0_COEFS : CH1_COEFS;
        fir_chan #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .TAPS   (TAPS),
            .ACC_W  (ACC_W),
            .CW     (CW),
            .COEFS  (KERN)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .feed_i      (st == FB_RUN),
            .flush_i     (st == FB_DRAIN),
            .load_we_i   (st == FB_LOAD),
            .load_idx_i  (step),
            .data_i      (din[g]),
            .valid_i     (dvld[g]),
            .res_o       (res[g]),
            .res_valid_o (rvld[g])
        );
    end

    assign ch0_res_o     = res[0];
    assign ch0_res_vld_o = rvld[0];
    assign ch1_res_o     = res[1];
    assign ch1_res_vld_o = rvld[1];
    assign state_o       = st;

endmodule

// File: rtl/fir_bank_chk.sv
// Property checker for the filter bank, attached by bind.
// Observes only top-level ports; counts phase lengths with local counters.
module fir_bank_chk
    import dual_fir_pkg::*;
#(
    parameter int TAPS = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       in_done_i,
    input logic [2:0] state_i,
    input logic       vld0_i,
    input logic       vld1_i
);

    localparam int CW = $clog2(TAPS + MAC_LAT + 2);

    logic [CW-1:0] lcnt_q;
    logic [CW-1:0] dcnt_q;

    // Count consecutive cycles spent in loading and in draining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcnt_q <= '0;
            dcnt_q <= '0;
        end else begin
            lcnt_q <= (state_i == FB_LOAD)  ? lcnt_q + 1'b1 : '0;
            dcnt_q <= (state_i == FB_DRAIN) ? dcnt_q + 1'b1 : '0;
        end
    end

    p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_i <= 3'd4);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == FB_IDLE && start_i) |=> state_i == FB_LOAD);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == FB_IDLE && !start_i) |=> state_i == FB_IDLE);

    p_load_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == FB_RUN && $past(state_i) == FB_LOAD) |-> lcnt_q == CW'(TAPS));

    p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == FB_RUN && !in_done_i) |=> state_i == FB_RUN);

    p_valid_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld0_i || vld1_i) |->
            ($past(state_i, 3) == FB_RUN || $past(state_i, 3) == FB_DRAIN));

    p_drain_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == FB_RUN && in_done_i) |=> state_i == FB_DRAIN);

    p_drain_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == FB_DONE && $past(state_i) == FB_DRAIN) |->
            dcnt_q == CW'(TAPS + MAC_LAT));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_i == FB_DONE |=> state_i == FB_DONE);

endmodule

bind dual_fir_bank fir_bank_chk #(.TAPS(TAPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .in_done_i (in_done_i),
    .state_i   (state_o),
    .vld0_i    (ch0_res_vld_o),
    .vld1_i    (ch1_res_vld_o)
);

// File: tb/sim_dual_fir_bank.sv
`timescale 1ns/1ps
// Self-checking bench: drives sample patterns on both channels and compares
// each cycle against an arithmetic model of the requirements.
module sim_dual_fir_bank;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic               in_done_i = 1'b0;
    logic [15:0]        d0 = '0;
    logic [15:0]        d1 = '0;
    logic               v0 = 1'b0;
    logic               v1 = 1'b0;
    logic signed [21:0] r0;
    logic signed [21:0] r1;
    logic               rv0;
    logic               rv1;
    logic [2:0]         st;

    int nchk = 0;
    int nfail = 0;

    // Model state, derived from the requirements only.
    int est = 0;
    int ecnt = 0;
    int coef [2][3];
    int hist [2][3];
    int pv_v [2][3];
    int pv_y [2][3];
    string vtag = "R4";
    string dtag = "R5";

    always #2 clk = ~clk;

    dual_fir_bank u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .in_done_i     (in_done_i),
        .ch0_data_i    (d0),
        .ch0_valid_i   (v0),
        .ch1_data_i    (d1),
        .ch1_valid_i   (v1),
        .ch0_res_o     (r0),
        .ch0_res_vld_o (rv0),
        .ch1_res_o     (r1),
        .ch1_res_vld_o (rv1),
        .state_o       (st)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string state_tag(input int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R3";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic clear_model();
        est = 0;
        ecnt = 0;
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 3; k++) begin
                hist[c][k] = 0;
                pv_v[c][k] = 0;
                pv_y[c][k] = 0;
            end
        end
    endtask

    // One clock: apply inputs, advance the model, compare outputs after the edge.
    task automatic step(input bit s, input bit dn, input bit va, input int da,
                        input bit vb, input int db);
        int  pre;
        bit  acc [2];
        int  xin [2];
        int  y;
        start_i = s;
        in_done_i = dn;
        v0 = va;
        v1 = vb;
        d0 = 16'(da);
        d1 = 16'(db);
        pre = est;
        acc[0] = (pre == 2 && va) || pre == 3;
        acc[1] = (pre == 2 && vb) || pre == 3;
        xin[0] = (pre == 3) ? 0 : da;
        xin[1] = (pre == 3) ? 0 : db;
        case (est)
            0: if (s) begin est = 1; ecnt = 0; end
            1: if (ecnt == 2) begin est = 2; ecnt = 0; end else ecnt++;
            2: if (dn) begin est = 3; ecnt = 0; end
            3: if (ecnt == 4) begin est = 4; ecnt = 0; end else ecnt++;
            default: est = 4;
        endcase
        @(posedge clk);
        for (int c = 0; c < 2; c++) begin
            if (acc[c]) begin
                hist[c][2] = hist[c][1];
                hist[c][1] = hist[c][0];
                hist[c][0] = xin[c];
            end
            y = 0;
            for (int k = 0; k < 3; k++) y += coef[c][k] * hist[c][k];
            pv_v[c][2] = pv_v[c][1];
            pv_y[c][2] = pv_y[c][1];
            pv_v[c][1] = pv_v[c][0];
            pv_y[c][1] = pv_y[c][0];
            pv_v[c][0] = acc[c] ? 1 : 0;
            pv_y[c][0] = y;
        end
        @(negedge clk);
        chk(int'(st) == est, state_tag(est), "state", int'(st), est);
        chk(int'(rv0) == pv_v[0][2], vtag, "ch0 valid", int'(rv0), pv_v[0][2]);
        chk(int'(rv1) == pv_v[1][2], vtag, "ch1 valid", int'(rv1), pv_v[1][2]);
        if (rv0 && pv_v[0][2] == 1)
            chk(int'(r0) == pv_y[0][2], dtag, "ch0 result", int'(r0), pv_y[0][2]);
        if (rv1 && pv_v[1][2] == 1)
            chk(int'(r1) == pv_y[1][2], dtag, "ch1 result", int'(r1), pv_y[1][2]);
    endtask

    // R1: synchronous reset returns everything to its idle, cleared state.
    task automatic do_reset();
        rst_n = 1'b0;
        start_i = 1'b0;
        in_done_i = 1'b0;
        v0 = 1'b0;
        v1 = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        clear_model();
        chk(st == 3'd0, "R1", "state after reset", int'(st), 0);
        chk(rv0 == 1'b0, "R1", "ch0 valid after reset", int'(rv0), 0);
        chk(rv1 == 1'b0, "R1", "ch1 valid after reset", int'(rv1), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        coef[0][0] = 1; coef[0][1] = 2;  coef[0][2] = 1;
        coef[1][0] = 1; coef[1][1] = -2; coef[1][2] = 1;
        clear_model();
        @(negedge clk);
        do_reset();

        // R6: valid samples in idle are ignored.
        vtag = "R6";
        for (int i = 0; i < 3; i++) step(0, 0, 1, 777, 1, -777);
        // R2: start pulse, then R6: samples during loading are ignored.
        step(1, 0, 1, 500, 1, 500);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 500, 1, -500);

        // R5: impulse response reproduces each kernel.
        vtag = "R4";
        dtag = "R5";
        step(0, 0, 1, 1, 1, 1);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 1, 0);
        // R6: gap with valid low; R2: start ignored while running.
        vtag = "R6";
        step(0, 0, 0, 1234, 0, 4321);
        step(1, 0, 0, 99, 0, 99);
        vtag = "R4";
        // R4/R5: sweep with independent per-channel valid patterns.
        for (int i = 0; i < 16; i++) begin
            step(0, 0, (i % 3) != 2, (i * 4099) - 32768,
                       (i % 4) != 1, 32767 - i * 4369);
        end
        // R9: full-scale extremes.
        dtag = "R9";
        for (int i = 0; i < 6; i++)
            step(0, 0, 1, (i % 2) ? 32767 : -32768, 1, (i % 2) ? -32768 : 32767);
        for (int i = 0; i < 4; i++) step(0, 0, 1, -32768, 1, 32767);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 32767, 1, -32768);
        // R7: input-done with a valid sample, then the drain phase.
        dtag = "R7";
        vtag = "R7";
        step(0, 1, 1, 300, 1, -300);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 8888, 1, 8888);
        // R8: done holds and ignores start and samples.
        vtag = "R8";
        for (int i = 0; i < 6; i++) step(i % 2, 0, 1, 55, 1, 55);

        // R1: reset mid-run, then a fresh impulse must show no stale history.
        do_reset();
        vtag = "R4";
        dtag = "R5";
        step(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 9999, 1, -9999);
        step(0, 0, 1, 9999, 1, -9999);
        do_reset();
        vtag = "R1";
        dtag = "R1";
        step(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 1, 1);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 1, 0);

        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule